// File: doc/BRIEF.md
# Rule-programmable Ethernet frame classifier

This block sits on the receive side of an Ethernet port. It watches each incoming frame as a stream of 16-bit words and sorts it into one of eight classes. A small program decides the class. The program is held in a 64-entry rule table that is written through a simple write port. A rule is one of two kinds:

- A masked word compare, which fires at a fixed word offset within the frame.
- A boolean rule over two or three operands.

Every rule writes its result into one bit of a 32-entry bank of 1-bit result registers. The class bits are registers 24 to 31: class 0 is register 24 and class 7 is register 31.

When the last word of a frame has been taken, the block runs every logic rule once, in table order, one rule per cycle. It then shows the eight class bits for a single cycle. Alongside them it gives the index of the winning class and a destination select. The destination names one of three sinks: the timing CPU, the remote memory-access engine, or the host NIC path. A frame is never dropped. A frame whose class bits are all clear goes to the host path.

A typical program compares:

- the EtherType at word 6;
- the IP protocol byte at word 11;
- the UDP destination port at word 18, where 0x0044 marks BOOTP client traffic and 0xEBD0 marks remote-access traffic;
- a magic value 0x4E6F at word 21.

Logic rules then combine these compare results into class 0 (control traffic to the CPU), class 5 (remote access) and class 7 (everything else).

Top module: `pkt_cls_top`

## Requirements
- R1: A cycle with `cfg_we` high stores `cfg_wdata` into rule entry `cfg_addr`; the table has 64 entries, all cleared to no-op by reset. Entry layout, from the MSB down: opcode[75:74] (0 no-op, 1 compare, 2 two-operand logic, 3 three-operand logic), op1[73:71], op2[70:68], dst[67:63], src_a[62:58], src_b[57:53], src_c[52:48], offset[47:32], value[31:16], mask[15:0].
- R2: The word taken with `in_sof` has index 0, and each later word taken has the next index. A compare rule whose offset equals the index of the word being taken writes 1 into register dst when ((word XOR value) AND mask) is zero, and writes 0 otherwise. When several compare rules write the same register on one word, the highest-numbered rule wins.
- R3: A compare rule whose offset is not reached before the last word of a frame leaves its destination register at 0.
- R4: All 32 result registers are cleared when a frame's first word is taken, before that word's compares are applied; no result carries over from one frame to the next.
- R5: After the last word, the logic rules run in table order, one entry per cycle, and each rule sees the results written by the rules before it. A two-operand rule writes dst = a op1 b. A three-operand rule writes dst = (a op1 b) op2 c. Operator codes are 0 AND, 1 OR, 2 XOR, 3 MOV (the left operand), 4 NOT (the inverse of the left operand), and the codes 5 to 7 give 0.
- R6: If the last word of a frame is taken on clock edge k, `class_valid` is high for exactly the one cycle that follows edge k+64.
- R7: While `class_valid` is high, bit i of `class_vec` is result register 24+i.
- R8: While `class_valid` is high:
  - `class_id` is the lowest set bit of `class_vec`, or 7 if no bit is set.
  - `class_dest` is 0 (timing CPU) when that class is 0, 1 (remote-access engine) when it is 5, and 2 (host NIC) for any other class.
- R9: Words that arrive while the rules are being evaluated or the result is being shown are ignored; they change neither the current result nor the number of results.
- R10: After reset, `class_valid` is low and `class_vec` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rule table write enable |
| cfg_addr | input | 6 | Rule entry index |
| cfg_wdata | input | 76 | Rule entry contents |
| in_valid | input | 1 | Frame word valid |
| in_sof | input | 1 | Marks the first word of a frame |
| in_eof | input | 1 | Marks the last word of a frame |
| in_word | input | 16 | Frame word |
| class_valid | output | 1 | One-cycle result strobe |
| class_vec | output | 8 | Class result bits (registers 24 to 31) |
| class_id | output | 3 | Lowest set class, or 7 if none is set |
| class_dest | output | 2 | Destination: 0 CPU, 1 remote engine, 2 host |

## Verification
The bench loads a control-traffic program into the rule table. It then sweeps 120 frames built from these choices:

- four EtherTypes;
- five pairs of TTL and protocol byte;
- three UDP ports;
- two magic words.

The sweep separates ARP, PTP, ICMP and BOOTP control frames from remote-access frames and from the frames that fall through to the host. Because TTL values and non-UDP protocols vary, the sweep also shows that masked compares ignore the unmasked byte.

Four further sets of frames test single cases:

- Frames cut short before word 21 and single-word frames show that unreached offsets stay clear and that results reset between frames.
- A rule added at run time sets two class bits at once, which tests the lowest-class priority.
- A whole frame is injected during evaluation, which shows that it is ignored.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;

    localparam int WORD_W       = 16;
    localparam int N_REGS       = 32;
    localparam int REG_IW       = $clog2(N_REGS);
    localparam int N_CLASS      = 8;
    localparam int CLASS_IW     = $clog2(N_CLASS);
    localparam int CLASS_BASE   = 24;
    localparam int CPU_CLASS    = 0;
    localparam int REMOTE_CLASS = 5;

    typedef enum logic [1:0] {
        OPC_NOP    = 2'd0,
        OPC_CMP    = 2'd1,
        OPC_LOGIC2 = 2'd2,
        OPC_LOGIC3 = 2'd3
    } opc_e;

    typedef enum logic [2:0] {
        BOP_AND = 3'd0,
        BOP_OR  = 3'd1,
        BOP_XOR = 3'd2,
        BOP_MOV = 3'd3,
        BOP_NOT = 3'd4
    } bop_e;

    typedef enum logic [1:0] {
        DST_CPU    = 2'd0,
        DST_REMOTE = 2'd1,
        DST_HOST   = 2'd2
    } dest_e;

    typedef enum logic [1:0] {
        ST_RECV = 2'd0,
        ST_EVAL = 2'd1,
        ST_OUT  = 2'd2
    } state_e;

    typedef struct packed {
        opc_e               opc;
        bop_e               op1;
        bop_e               op2;
        logic [REG_IW-1:0]  dst;
        logic [REG_IW-1:0]  src_a;
        logic [REG_IW-1:0]  src_b;
        logic [REG_IW-1:0]  src_c;
        logic [WORD_W-1:0]  offset;
        logic [WORD_W-1:0]  value;
        logic [WORD_W-1:0]  mask;
    } rule_t;

    localparam int RULE_W = $bits(rule_t);

    function automatic logic bool_op(input bop_e op, input logic x, input logic y);
        logic r;
        case (op)
            BOP_AND: r = x & y;
            BOP_OR:  r = x | y;
            BOP_XOR: r = x ^ y;
            BOP_MOV: r = x;
            BOP_NOT: r = ~x;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic word_match(input logic [WORD_W-1:0] w,
                                        input logic [WORD_W-1:0] v,
                                        input logic [WORD_W-1:0] m);
        return ((w ^ v) & m) == '0;
    endfunction

endpackage

// File: rtl/pkt_cls_rule_mem.sv
module pkt_cls_rule_mem
    import pkt_cls_pkg::*;
#(
    parameter int N_RULES = 64,
    localparam int AW = $clog2(N_RULES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  rule_t         wdata,
    input  logic [AW-1:0] raddr,
    output rule_t         rdata,
    output rule_t         table_o [N_RULES]
);

    rule_t mem [N_RULES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_RULES; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata   = mem[raddr];
    assign table_o = mem;

endmodule

// File: rtl/pkt_cls_cmp_bank.sv
module pkt_cls_cmp_bank
    import pkt_cls_pkg::*;
#(
    parameter int N_RULES = 64
) (
    input  rule_t              rules [N_RULES],
    input  logic [WORD_W-1:0]  word,
    input  logic [WORD_W-1:0]  widx,
    output logic [N_REGS-1:0]  wr_en,
    output logic [N_REGS-1:0]  wr_val
);

    logic [N_RULES-1:0] hit;
    logic [N_RULES-1:0] match;

    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        assign hit[g]   = (rules[g].opc == OPC_CMP) && (rules[g].offset == widx);
        assign match[g] = word_match(word, rules[g].value, rules[g].mask);
    end

    // higher-numbered rules override lower ones on the same register
    always_comb begin
        wr_en  = '0;
        wr_val = '0;
        for (int i = 0; i < N_RULES; i++) begin
            if (hit[i]) begin
                wr_en[rules[i].dst]  = 1'b1;
                wr_val[rules[i].dst] = match[i];
            end
        end
    end

endmodule

// File: rtl/pkt_cls_logic_unit.sv
module pkt_cls_logic_unit
    import pkt_cls_pkg::*;
(
    input  rule_t              rule,
    input  logic [N_REGS-1:0]  regs,
    output logic               wr_en,
    output logic [REG_IW-1:0]  wr_idx,
    output logic               wr_val
);

    logic opnd_a, opnd_b, opnd_c, stage1;

    assign opnd_a = regs[rule.src_a];
    assign opnd_b = regs[rule.src_b];
    assign opnd_c = regs[rule.src_c];
    assign stage1 = bool_op(rule.op1, opnd_a, opnd_b);
    assign wr_idx = rule.dst;

    always_comb begin
        case (rule.opc)
            OPC_LOGIC2: begin
                wr_en  = 1'b1;
                wr_val = stage1;
            end
            OPC_LOGIC3: begin
                wr_en  = 1'b1;
                wr_val = bool_op(rule.op2, stage1, opnd_c);
            end
            default: begin
                wr_en  = 1'b0;
                wr_val = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pkt_cls_dest_sel.sv
module pkt_cls_dest_sel
    import pkt_cls_pkg::*;
(
    input  logic [N_CLASS-1:0]   vec,
    output logic [CLASS_IW-1:0]  id,
    output dest_e                dest
);

    logic found;

    always_comb begin
        id    = CLASS_IW'(N_CLASS - 1);
        found = 1'b0;
        for (int i = 0; i < N_CLASS; i++) begin
            if (vec[i] && !found) begin
                id    = CLASS_IW'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (id == CLASS_IW'(CPU_CLASS))         dest = DST_CPU;
        else if (id == CLASS_IW'(REMOTE_CLASS)) dest = DST_REMOTE;
        else                                    dest = DST_HOST;
    end

endmodule

// File: rtl/pkt_cls_top.sv
module pkt_cls_top
    import pkt_cls_pkg::*;
#(
    parameter int N_RULES = 64,
    localparam int AW = $clog2(N_RULES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [RULE_W-1:0]   cfg_wdata,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic [WORD_W-1:0]   in_word,
    output logic                class_valid,
    output logic [N_CLASS-1:0]  class_vec,
    output logic [CLASS_IW-1:0] class_id,
    output logic [1:0]          class_dest
);

    state_e              state;
    logic [AW-1:0]       ev_idx;
    logic [WORD_W-1:0]   next_idx;
    logic [N_REGS-1:0]   regs;

    rule_t               table_w [N_RULES];
    rule_t               ev_rule;
    logic                accept, eof_take;
    logic [WORD_W-1:0]   widx;
    logic [N_REGS-1:0]   cmp_en, cmp_val, base_regs, regs_cmp;
    logic                lu_en, lu_val;
    logic [REG_IW-1:0]   lu_idx;
    dest_e               dest;

    pkt_cls_rule_mem #(.N_RULES(N_RULES)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .waddr   (cfg_addr),
        .wdata   (rule_t'(cfg_wdata)),
        .raddr   (ev_idx),
        .rdata   (ev_rule),
        .table_o (table_w)
    );

    pkt_cls_cmp_bank #(.N_RULES(N_RULES)) u_cmp (
        .rules  (table_w),
        .word   (in_word),
        .widx   (widx),
        .wr_en  (cmp_en),
        .wr_val (cmp_val)
    );

    pkt_cls_logic_unit u_lu (
        .rule   (ev_rule),
        .regs   (regs),
        .wr_en  (lu_en),
        .wr_idx (lu_idx),
        .wr_val (lu_val)
    );

    pkt_cls_dest_sel u_sel (
        .vec  (class_vec),
        .id   (class_id),
        .dest (dest)
    );

    assign accept    = (state == ST_RECV) && in_valid;
    assign eof_take  = accept && in_eof;
    assign widx      = in_sof ? '0 : next_idx;
    assign base_regs = in_sof ? '0 : regs;
    assign regs_cmp  = (base_regs & ~cmp_en) | (cmp_val & cmp_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RECV;
            ev_idx   <= '0;
            next_idx <= '0;
            regs     <= '0;
        end else begin
            case (state)
                ST_RECV: begin
                    if (accept) begin
                        regs     <= regs_cmp;
                        next_idx <= (widx == '1) ? widx : widx + 1'b1;
                        if (in_eof) begin
                            state  <= ST_EVAL;
                            ev_idx <= '0;
                        end
                    end
                end
                ST_EVAL: begin
                    if (lu_en) regs[lu_idx] <= lu_val;
                    if (ev_idx == AW'(N_RULES - 1)) state <= ST_OUT;
                    else                            ev_idx <= ev_idx + 1'b1;
                end
                default: state <= ST_RECV;
            endcase
        end
    end

    assign class_valid = (state == ST_OUT);
    assign class_vec   = regs[CLASS_BASE +: N_CLASS];
    assign class_dest  = dest;

endmodule

// File: rtl/pkt_cls_checker.sv
module pkt_cls_checker
    import pkt_cls_pkg::*;
#(
    parameter int N_RULES = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                class_valid,
    input logic [N_CLASS-1:0]  class_vec,
    input logic [CLASS_IW-1:0] class_id,
    input logic [1:0]          class_dest,
    input logic                eof_take
);

    logic [15:0] since_eof;

    always_ff @(posedge clk) begin
        if (rst)                      since_eof <= 16'hFFFF;
        else if (eof_take)            since_eof <= 16'd0;
        else if (since_eof != 16'hFFFF) since_eof <= since_eof + 16'd1;
    end

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> !class_valid);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        class_valid |=> !class_valid);

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        class_valid |-> (since_eof == 16'(N_RULES)));

    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (class_valid && class_vec != '0) |->
            (class_vec[class_id] && ((class_vec & ((8'd1 << class_id) - 8'd1)) == 8'd0)));

    assert_empty_to_host_R8: assert property (@(posedge clk) disable iff (rst)
        (class_valid && class_vec == '0) |->
            (class_dest == 2'd2 && class_id == CLASS_IW'(N_CLASS - 1)));

    assert_cpu_route_R8: assert property (@(posedge clk) disable iff (rst)
        (class_valid && class_vec[CPU_CLASS]) |-> (class_dest == 2'd0));

endmodule

bind pkt_cls_top pkt_cls_checker #(.N_RULES(N_RULES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .class_valid (class_valid),
    .class_vec   (class_vec),
    .class_id    (class_id),
    .class_dest  (class_dest),
    .eof_take    (eof_take)
);

// File: tb/tb_pkt_cls_top.sv
module tb_pkt_cls_top;

    localparam int RW = 76;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [5:0]    cfg_addr;
    logic [RW-1:0] cfg_wdata;
    logic          in_valid, in_sof, in_eof;
    logic [15:0]   in_word;
    logic          class_valid;
    logic [7:0]    class_vec;
    logic [2:0]    class_id;
    logic [1:0]    class_dest;

    int n_chk = 0;
    int n_err = 0;

    int         seen_cnt, seen_at;
    logic [7:0] got_vec;
    logic [2:0] got_id;
    logic [1:0] got_dest;

    always #4 clk = ~clk;

    pkt_cls_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_word(in_word),
        .class_valid(class_valid), .class_vec(class_vec), .class_id(class_id),
        .class_dest(class_dest)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk(input int opc, input int op1, input int op2,
                                         input int dst, input int sa, input int sb,
                                         input int sc, input int off, input int val,
                                         input int msk);
        return {opc[1:0], op1[2:0], op2[2:0], dst[4:0], sa[4:0], sb[4:0], sc[4:0],
                off[15:0], val[15:0], msk[15:0]};
    endfunction

    task automatic wr_rule(input int a, input logic [RW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[5:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] fw(input int k, input logic [15:0] et, input logic [15:0] tp,
                                       input logic [15:0] dp, input logic [15:0] mg);
        case (k)
            6:  return et;
            11: return tp;
            18: return dp;
            21: return mg;
            default: return 16'h1000 + 16'(k);
        endcase
    endfunction

    function automatic logic [7:0] exp_vec(input logic [15:0] et, input logic [15:0] tp,
                                           input logic [15:0] dp, input logic [15:0] mg,
                                           input int len, input bit extra);
        bit ip, arp, ptp, icmp, udp, boot, eb, ctrl;
        logic [7:0] v;
        arp  = len > 6  && et == 16'h0806;
        ptp  = len > 6  && et == 16'h88F7;
        ip   = len > 6  && et == 16'h0800;
        icmp = ip && len > 11 && tp[7:0] == 8'h01;
        udp  = ip && len > 11 && tp[7:0] == 8'h11;
        boot = udp && len > 18 && dp == 16'h0044;
        eb   = udp && len > 18 && dp == 16'hEBD0 && len > 21 && mg == 16'h4E6F;
        ctrl = arp | ptp | icmp | boot;
        v = '0;
        v[0] = ctrl;
        v[5] = eb;
        v[7] = !(ctrl | eb);
        v[1] = extra && ip;
        return v;
    endfunction

    function automatic int low_id(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 7;
    endfunction

    function automatic int dest_of(input int id);
        return (id == 0) ? 0 : (id == 5) ? 1 : 2;
    endfunction

    task automatic send_frame(input logic [15:0] et, input logic [15:0] tp, input logic [15:0] dp,
                              input logic [15:0] mg, input int len, input bit inject);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == len - 1);
            in_word = fw(k, et, tp, dp, mg);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        seen_cnt = 0; seen_at = -1;
        for (int j = 1; j <= 70; j++) begin
            @(negedge clk);
            if (class_valid) begin
                seen_cnt++;
                if (seen_at < 0) begin
                    seen_at = j; got_vec = class_vec; got_id = class_id; got_dest = class_dest;
                end
            end
            if (inject && j >= 3 && j <= 9) begin
                in_valid = 1'b1; in_sof = (j == 3); in_eof = (j == 9);
                in_word = fw(j - 3, 16'h0806, 16'h4001, 16'h0044, 16'h4E6F);
            end else begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            end
        end
    endtask

    task automatic frame_check(input logic [15:0] et, input logic [15:0] tp, input logic [15:0] dp,
                               input logic [15:0] mg, input int len, input bit extra,
                               input string tag);
        logic [7:0] ev;
        int eid;
        send_frame(et, tp, dp, mg, len, 1'b0);
        ev  = exp_vec(et, tp, dp, mg, len, extra);
        eid = low_id(ev);
        check(seen_cnt == 1 && seen_at == 64, {tag, " R6 strobe timing"}, seen_at, 64);
        check(got_vec == ev, {tag, " R2 R5 R7 class vector"}, int'(got_vec), int'(ev));
        check(int'(got_id) == eid, {tag, " R8 class id"}, int'(got_id), eid);
        check(int'(got_dest) == dest_of(eid), {tag, " R8 destination"}, int'(got_dest),
              dest_of(eid));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [15:0] ets [4];
        logic [15:0] tps [5];
        logic [15:0] dps [3];
        logic [15:0] mgs [2];
        ets = '{16'h0806, 16'h88F7, 16'h0800, 16'h86DD};
        tps = '{16'h4001, 16'hFF01, 16'h4011, 16'hFF11, 16'h8006};
        dps = '{16'h0044, 16'hEBD0, 16'h0035};
        mgs = '{16'h4E6F, 16'h0000};

        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(class_valid == 1'b0, "R10 valid low after reset", int'(class_valid), 0);
        check(class_vec == 8'h00, "R10 class bits clear after reset", int'(class_vec), 0);

        // R1: program the control-traffic rule set (opcode 1 cmp, 2 logic2, 3 logic3)
        wr_rule(0,  mk(1, 0, 0, 1, 0, 0, 0, 6,  16'h0806, 16'hFFFF));
        wr_rule(1,  mk(1, 0, 0, 2, 0, 0, 0, 6,  16'h88F7, 16'hFFFF));
        wr_rule(2,  mk(1, 0, 0, 3, 0, 0, 0, 6,  16'h0800, 16'hFFFF));
        wr_rule(3,  mk(1, 0, 0, 4, 0, 0, 0, 11, 16'h0001, 16'h00FF));
        wr_rule(4,  mk(1, 0, 0, 5, 0, 0, 0, 11, 16'h0011, 16'h00FF));
        wr_rule(5,  mk(1, 0, 0, 6, 0, 0, 0, 18, 16'hEBD0, 16'hFFFF));
        wr_rule(6,  mk(1, 0, 0, 7, 0, 0, 0, 21, 16'h4E6F, 16'hFFFF));
        wr_rule(7,  mk(1, 0, 0, 8, 0, 0, 0, 18, 16'h0044, 16'hFFFF));
        wr_rule(8,  mk(2, 0, 0, 10, 3, 4, 0, 0, 0, 0));
        wr_rule(9,  mk(3, 1, 1, 11, 1, 2, 10, 0, 0, 0));
        wr_rule(10, mk(3, 0, 0, 12, 3, 5, 8, 0, 0, 0));
        wr_rule(11, mk(2, 1, 0, 13, 11, 12, 0, 0, 0, 0));
        wr_rule(12, mk(3, 0, 0, 14, 3, 5, 6, 0, 0, 0));
        wr_rule(13, mk(2, 0, 0, 14, 14, 7, 0, 0, 0, 0));
        wr_rule(14, mk(2, 3, 0, 24, 13, 0, 0, 0, 0, 0));
        wr_rule(15, mk(2, 1, 0, 29, 14, 0, 0, 0, 0, 0));
        wr_rule(16, mk(3, 1, 4, 31, 13, 14, 0, 0, 0, 0));

        // R2 R5 R7 R8: sweep of header contents
        foreach (ets[a]) foreach (tps[b]) foreach (dps[c]) foreach (mgs[d])
            frame_check(ets[a], tps[b], dps[c], mgs[d], 24, 1'b0, "sweep");

        // R3: frames end before word 21 or word 18
        frame_check(16'h0800, 16'h4011, 16'hEBD0, 16'h4E6F, 21, 1'b0, "R3 short21");
        frame_check(16'h0800, 16'h4011, 16'h0044, 16'h4E6F, 18, 1'b0, "R3 short18");

        // R4: control frame followed by single-word frame must not inherit bits
        frame_check(16'h0806, 16'h0000, 16'h0000, 16'h0000, 24, 1'b0, "R4 first");
        frame_check(16'h0806, 16'h0000, 16'h0000, 16'h0000, 1,  1'b0, "R4 oneword");
        check(got_vec == 8'h80, "R4 cleared regs give host class", int'(got_vec), 8'h80);

        // R1 R8: runtime rule adds class 1 for any IPv4 frame; lowest class wins
        wr_rule(20, mk(2, 3, 0, 25, 3, 0, 0, 0, 0, 0));
        frame_check(16'h0800, 16'h4001, 16'h0035, 16'h0000, 24, 1'b1, "R8 prio icmp");
        frame_check(16'h0800, 16'h4011, 16'hEBD0, 16'h4E6F, 24, 1'b1, "R8 prio remote");
        check(int'(got_id) == 1 && got_dest == 2'd2, "R8 class1 beats class5 to host",
              int'(got_id), 1);
        // R1: overwrite the entry back to no-op
        wr_rule(20, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        frame_check(16'h0800, 16'h4001, 16'h0035, 16'h0000, 24, 1'b0, "R1 overwrite");

        // R9: a whole frame arriving during evaluation is ignored
        send_frame(16'h0800, 16'h4011, 16'hEBD0, 16'h4E6F, 24, 1'b1);
        check(seen_cnt == 1, "R9 single result despite injected frame", seen_cnt, 1);
        check(got_vec == 8'h20, "R9 injected words do not alter result", int'(got_vec), 8'h20);
        frame_check(16'h86DD, 16'h4011, 16'h0035, 16'h0000, 24, 1'b0, "R9 after inject");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule